// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Synchronous Updates

This block drives four independent pulse-width outputs. It is configured through a simple 32-bit register bus with separate read and write strobes. Each channel counts prescaled clock ticks up to a programmable period length. The output stays at its inactive level for the first part of each period. The length of that inactive part is set by the duty value, and the rest of the period is active. A polarity bit selects which logic level counts as active.

Software changes the duty or the period of a running channel through update registers. These hold the new value and copy it into the working register only when the current period wraps, so no period is ever cut short or stretched. A per-channel flag, cleared when software reads it, marks every period start, so software can tell when a queued value has taken effect. A stop request also waits for the end of the current period, and the channel's running status bit stays set until the channel has actually stopped.

Top module: `pwm_quad`

## Requirements
- R1: After reset every channel is stopped, every output is 0, and reads of the status (0x0C) and period-start flags (0x1C) return 0.
- R2: Writing 0x04 with bit i set starts stopped channel i. Its tick counter restarts from 0 on that edge. Bits [3:0] of 0x0C read 1 for each running channel.
- R3: A running channel with period P (offset 0x0C of its bank) and duty D (offset 0x04) is inactive for the first D ticks of each P-tick period and active for the rest. D >= P gives an output that never becomes active. D = 0 gives an output that is active all the time.
- R4: Mode bits [3:0] (bank offset 0x00) select N, and one tick lasts 2^N clocks. Values above 10 act as 10, but the field reads back exactly as written.
- R5: Mode bit 9 inverts the output. A stopped channel drives the inactive level: 0 when bit 9 is clear and 1 when it is set.
- R6: Writes to duty-update (bank offset 0x08) and period-update (0x10) are stored at once and read back from those offsets. They reach the working duty and period registers only at the edge where the period wraps, and never mid-period.
- R7: Writes to the mode, duty and period registers are ignored while the channel runs. They load on the write edge while it is stopped.
- R8: Writing 0x08 with bit i set stops running channel i at its next period wrap. The status bit clears and the output takes the inactive level on that same edge. A later start clears any leftover stop request.
- R9: At 0x1C, bit i is set at every period wrap of channel i. A read returns the flags and clears them all. A wrap that falls on the read edge stays set for the next read.
- R10: Bank i starts at 0x200 + 0x20*i. Read data appears on busRdData on the edge after busRdEn and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busRdEn | input | 1 | Read strobe, one clock per read |
| busAddr | input | 10 | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| pwmOut | output | 4 | One pulse output per channel |

## Verification
The hardest cases to reach from the ports are edges where two actions land at once: a flag read on the same edge as a period wrap, and a duty-update write on a wrap edge, where the new value must wait a whole further period. The stimulus reads the flag register on every clock for dozens of cycles, and writes the duty-update register on every clock for a stretch. It does this on a channel with an 8-clock period, so every phase of the period gets hit. A reference model in the bench tracks counters, flags and pending updates. It is compared with the outputs and the read data on every clock, so a wrong choice of which value wins on a shared edge shows up at once.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 16;
  localparam int PRE_W   = 4;
  localparam int MAX_PRE = 10;
  localparam int POL_BIT = 9;

  localparam int OFS_ENA   = 'h04;
  localparam int OFS_DIS   = 'h08;
  localparam int OFS_STAT  = 'h0C;
  localparam int OFS_FLAGS = 'h1C;

  localparam int CHAN_BASE = 'h200;
  localparam int BANK_SH   = 5;
  localparam int OFS_MODE       = 'h00;
  localparam int OFS_DUTY       = 'h04;
  localparam int OFS_DUTY_UPD   = 'h08;
  localparam int OFS_PERIOD     = 'h0C;
  localparam int OFS_PERIOD_UPD = 'h10;

  typedef struct packed {
    logic enaSet;
    logic disReq;
    logic wrMode;
    logic wrDuty;
    logic wrPeriod;
    logic wrDutyUpd;
    logic wrPeriodUpd;
  } chanStrobe_t;

  typedef struct packed {
    logic             pol;
    logic [PRE_W-1:0] preSel;
    logic [CNT_W-1:0] duty;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] dutyUpd;
    logic [CNT_W-1:0] periodUpd;
  } chanView_t;
endpackage

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobe_t      stb,
  input  logic [CNT_W-1:0] wrVal,
  output logic             running,
  output logic             periodStart,
  output logic             pwmOut,
  output chanView_t        view
);
  logic             pol;
  logic [PRE_W-1:0] preSel, preEff;
  logic [CNT_W-1:0] dutyAct, periodAct, dutyShd, periodShd, cnt;
  logic             dutyPend, periodPend, stopReq;
  logic [MAX_PRE-1:0] preCnt, preMask;
  logic [CNT_W:0]   cntNext;
  logic             tick, atEnd;

  always_comb begin
    preEff = (preSel > PRE_W'(MAX_PRE)) ? PRE_W'(MAX_PRE) : preSel;
    for (int i = 0; i < MAX_PRE; i++) preMask[i] = (i < int'(preEff));
  end

  assign tick        = running && (preCnt == preMask);
  assign cntNext     = {1'b0, cnt} + (CNT_W+1)'(1);
  assign atEnd       = cntNext >= {1'b0, periodAct};
  assign periodStart = tick && atEnd;
  assign pwmOut      = pol ^ (running && (cnt >= dutyAct));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0; stopReq <= 1'b0; pol <= 1'b0; preSel <= '0;
      dutyAct <= '0; periodAct <= '0; dutyShd <= '0; periodShd <= '0;
      dutyPend <= 1'b0; periodPend <= 1'b0; cnt <= '0; preCnt <= '0;
    end else begin
      if (running) preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) begin
        if (atEnd) begin
          cnt <= '0;
          if (dutyPend)   begin dutyAct   <= dutyShd;   dutyPend   <= 1'b0; end
          if (periodPend) begin periodAct <= periodShd; periodPend <= 1'b0; end
          if (stopReq)    begin running   <= 1'b0;      stopReq    <= 1'b0; end
        end else begin
          cnt <= cntNext[CNT_W-1:0];
        end
      end
      if (stb.enaSet && !running) begin
        running <= 1'b1; cnt <= '0; preCnt <= '0; stopReq <= 1'b0;
      end
      if (stb.disReq && running) stopReq <= 1'b1;
      if (!running) begin
        if (stb.wrMode) begin pol <= wrVal[POL_BIT]; preSel <= wrVal[PRE_W-1:0]; end
        if (stb.wrDuty)   dutyAct   <= wrVal;
        if (stb.wrPeriod) periodAct <= wrVal;
      end
      if (stb.wrDutyUpd)   begin dutyShd   <= wrVal; dutyPend   <= 1'b1; end
      if (stb.wrPeriodUpd) begin periodShd <= wrVal; periodPend <= 1'b1; end
    end
  end

  assign view = '{pol: pol, preSel: preSel, duty: dutyAct, period: periodAct,
                  dutyUpd: dutyShd, periodUpd: periodShd};

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    running && periodAct != '0 |-> cnt < periodAct);
  p_duty_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    running && $past(running) && !$past(periodStart) |-> $stable(dutyAct) && $stable(periodAct));
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> pwmOut == pol);
  p_stop_on_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(periodStart));
endmodule

// File: rtl/pwm_busctl.sv
module pwm_busctl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [NUM_CH-1:0]        wrMask,
  input  logic [NUM_CH-1:0]        runVec,
  input  logic [NUM_CH-1:0]        startVec,
  input  chanView_t [NUM_CH-1:0]   view,
  output chanStrobe_t [NUM_CH-1:0] stb,
  output logic [DATA_W-1:0]        busRdData
);
  localparam int BANK_W  = ADDR_W - BANK_SH;
  localparam int BANK_LO = CHAN_BASE >> BANK_SH;
  localparam int CH_W    = $clog2(NUM_CH);

  logic [BANK_W-1:0]  bankOff;
  logic [BANK_SH-1:0] regOff;
  logic [CH_W-1:0]    chanSel;
  logic               inChan, isEna, isDis, rdFlags;
  logic [NUM_CH-1:0]  flags;
  logic [DATA_W-1:0]  rdMux;
  chanView_t          selView;

  assign bankOff = busAddr[ADDR_W-1:BANK_SH] - BANK_W'(BANK_LO);
  assign regOff  = busAddr[BANK_SH-1:0];
  assign chanSel = bankOff[CH_W-1:0];
  assign inChan  = (busAddr >= ADDR_W'(CHAN_BASE)) && (bankOff < BANK_W'(NUM_CH));
  assign isEna   = busAddr == ADDR_W'(OFS_ENA);
  assign isDis   = busAddr == ADDR_W'(OFS_DIS);
  assign rdFlags = busRdEn && (busAddr == ADDR_W'(OFS_FLAGS));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_stb
    logic hit;
    assign hit = busWrEn && inChan && (chanSel == CH_W'(g));
    assign stb[g] = '{enaSet:      busWrEn && isEna && wrMask[g],
                      disReq:      busWrEn && isDis && wrMask[g],
                      wrMode:      hit && regOff == BANK_SH'(OFS_MODE),
                      wrDuty:      hit && regOff == BANK_SH'(OFS_DUTY),
                      wrPeriod:    hit && regOff == BANK_SH'(OFS_PERIOD),
                      wrDutyUpd:   hit && regOff == BANK_SH'(OFS_DUTY_UPD),
                      wrPeriodUpd: hit && regOff == BANK_SH'(OFS_PERIOD_UPD)};
  end

  always_comb begin
    rdMux   = '0;
    selView = view[chanSel];
    if (busAddr == ADDR_W'(OFS_STAT)) rdMux = DATA_W'(runVec);
    else if (busAddr == ADDR_W'(OFS_FLAGS)) rdMux = DATA_W'(flags);
    else if (inChan) begin
      case (regOff)
        BANK_SH'(OFS_MODE):       rdMux = (DATA_W'(selView.pol) << POL_BIT) | DATA_W'(selView.preSel);
        BANK_SH'(OFS_DUTY):       rdMux = DATA_W'(selView.duty);
        BANK_SH'(OFS_DUTY_UPD):   rdMux = DATA_W'(selView.dutyUpd);
        BANK_SH'(OFS_PERIOD):     rdMux = DATA_W'(selView.period);
        BANK_SH'(OFS_PERIOD_UPD): rdMux = DATA_W'(selView.periodUpd);
        default:                  rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags     <= '0;
      busRdData <= '0;
    end else begin
      flags <= (rdFlags ? '0 : flags) | startVec;
      if (busRdEn) busRdData <= rdMux;
    end
  end

  p_flags_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdFlags) && $past(startVec) == '0 |-> flags == '0);
  p_flags_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdFlags && startVec != '0 |=> (flags & $past(startVec)) == $past(startVec));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanStrobe_t [NUM_CH-1:0] stb;
  chanView_t   [NUM_CH-1:0] view;
  logic [NUM_CH-1:0] runVec, startVec;
  logic unusedHiBits;

  assign unusedHiBits = ^busWrData[DATA_W-1:CNT_W];

  pwm_busctl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .wrMask(busWrData[NUM_CH-1:0]), .runVec(runVec),
    .startVec(startVec), .view(view), .stb(stb), .busRdData(busRdData));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan u_chan (
      .clk(clk), .rstN(rstN), .stb(stb[g]), .wrVal(busWrData[CNT_W-1:0]),
      .running(runVec[g]), .periodStart(startVec[g]), .pwmOut(pwmOut[g]),
      .view(view[g]));
  end
endmodule

// File: tb/pwm_quad_tb.sv
module pwm_quad_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0, busRdEn = 1'b0;
  logic [9:0] busAddr = '0;
  logic [31:0] busWrData = '0, busRdData, rv;
  logic [NCH-1:0] pwmOut;
  int total = 0, bad = 0, cyc = 0;

  pwm_quad u_dut (.clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mRun[NCH], mCnt[NCH], mPre[NCH], mDuty[NCH], mPer[NCH], mDu[NCH], mPu[NCH];
  int mPd[NCH], mPp[NCH], mStop[NCH], mSel[NCH], mPol[NCH], oldRun[NCH];
  int mFlags = 0, startBits, a, d, n, c, o;
  logic [31:0] mRd = '0;

  function automatic logic [31:0] mRead(input int ad);
    int r = 0;
    if (ad == 'h0C) begin
      for (int k = 0; k < NCH; k++) r |= mRun[k] << k;
    end else if (ad == 'h1C) r = mFlags;
    else if (ad >= 'h200 && ad < 'h200 + NCH*'h20) begin
      int k = (ad - 'h200) / 'h20;
      case (ad % 'h20)
        'h00: r = (mPol[k] << 9) | mSel[k];
        'h04: r = mDuty[k];
        'h08: r = mDu[k];
        'h0C: r = mPer[k];
        'h10: r = mPu[k];
        default: r = 0;
      endcase
    end
    return 32'(r);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NCH; k++) begin
        mRun[k]=0; mCnt[k]=0; mPre[k]=0; mDuty[k]=0; mPer[k]=0; mDu[k]=0; mPu[k]=0;
        mPd[k]=0; mPp[k]=0; mStop[k]=0; mSel[k]=0; mPol[k]=0;
      end
      mFlags = 0; mRd = '0;
    end else begin
      a = int'(busAddr); d = int'(busWrData); startBits = 0;
      if (busRdEn) mRd = mRead(a);
      for (int k = 0; k < NCH; k++) begin
        oldRun[k] = mRun[k];
        if (mRun[k] != 0) begin
          n = (mSel[k] > 10) ? 10 : mSel[k];
          if (mPre[k] == (1 << n) - 1) begin
            mPre[k] = 0;
            if (mCnt[k] + 1 >= mPer[k]) begin
              mCnt[k] = 0; startBits |= 1 << k;
              if (mPd[k] != 0) begin mDuty[k] = mDu[k]; mPd[k] = 0; end
              if (mPp[k] != 0) begin mPer[k] = mPu[k]; mPp[k] = 0; end
              if (mStop[k] != 0) begin mRun[k] = 0; mStop[k] = 0; end
            end else mCnt[k]++;
          end else mPre[k]++;
        end
      end
      if (busRdEn && a == 'h1C) mFlags = 0;
      mFlags |= startBits;
      if (busWrEn) begin
        if (a == 'h04 || a == 'h08) begin
          for (int k = 0; k < NCH; k++) if (((d >> k) & 1) != 0) begin
            if (a == 'h04 && oldRun[k] == 0) begin
              mRun[k]=1; mCnt[k]=0; mPre[k]=0; mStop[k]=0;
            end
            if (a == 'h08 && oldRun[k] != 0) mStop[k] = 1;
          end
        end else if (a >= 'h200 && a < 'h200 + NCH*'h20) begin
          c = (a - 'h200) / 'h20; o = a % 'h20;
          case (o)
            'h00: if (oldRun[c] == 0) begin mSel[c] = d & 15; mPol[c] = (d >> 9) & 1; end
            'h04: if (oldRun[c] == 0) mDuty[c] = d & 'hFFFF;
            'h0C: if (oldRun[c] == 0) mPer[c] = d & 'hFFFF;
            'h08: begin mDu[c] = d & 'hFFFF; mPd[c] = 1; end
            'h10: begin mPu[c] = d & 'hFFFF; mPp[c] = 1; end
            default: ;
          endcase
        end
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      logic [NCH-1:0] ex;
      for (int k = 0; k < NCH; k++)
        ex[k] = 1'(mPol[k] ^ ((mRun[k] != 0 && mCnt[k] >= mDuty[k]) ? 1 : 0));
      total++;
      if (pwmOut !== ex) begin
        bad++;
        $display("FAIL R3 waveform (R4 R5 R6 R8) t=%0t act=%b exp=%b", $time, pwmOut, ex);
      end
      total++;
      if (busRdData !== mRd) begin
        bad++;
        $display("FAIL R10 read data t=%0t act=%h exp=%h", $time, busRdData, mRd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ad, input int dv);
    busWrEn = 1'b1; busAddr = 10'(ad); busWrData = 32'(dv);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int ad, output logic [31:0] v);
    busRdEn = 1'b1; busAddr = 10'(ad);
    @(negedge clk);
    busRdEn = 1'b0;
    v = busRdData;
  endtask

  task automatic idle(input int nc);
    repeat (nc) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk("R1 outputs after reset", 32'(pwmOut), 0);
    rd('h0C, rv); chk("R1 status after reset", rv, 0);
    rd('h1C, rv); chk("R1 flags after reset", rv, 0);

    wr('h200, 0);         wr('h20C, 8); wr('h204, 3);
    wr('h220, 'h201);     wr('h22C, 5); wr('h224, 0);
    wr('h240, 2);         wr('h24C, 4); wr('h244, 6);
    wr('h260, 12);        wr('h26C, 6); wr('h264, 2);
    rd('h260, rv); chk("R4 prescale field readback", rv, 12);
    rd('h220, rv); chk("R5 polarity readback", rv, 'h201);
    chk("R5 idle level of inverted channel", 32'(pwmOut[1]), 1);
    rd('h30C, rv); chk("R10 unmapped address", rv, 0);

    wr('h04, 'hF);
    idle(3);
    rd('h0C, rv); chk("R2 all channels running", rv, 'hF);
    wr('h204, 1);
    rd('h204, rv); chk("R7 direct duty ignored while running", rv, 3);
    wr('h208, 6);
    rd('h208, rv); chk("R6 duty-update readback", rv, 6);
    idle(20);
    rd('h204, rv); chk("R6 duty applied after wrap", rv, 6);
    chk("R3 duty above period keeps ch2 inactive", 32'(pwmOut[2]), 0);

    for (int i = 0; i < 40; i++) rd('h1C, rv);   // R9 read on every edge
    for (int i = 0; i < 16; i++) wr('h208, i % 9); // R6 writes across wrap edges
    wr('h210, 10);
    idle(30);
    rd('h20C, rv); chk("R6 period applied after wrap", rv, 10);

    wr('h08, 2);
    idle(30);
    rd('h0C, rv); chk("R8 ch1 stopped", rv, 'hD);
    chk("R8 ch1 at inactive level", 32'(pwmOut[1]), 1);

    wr('h08, 'hF);
    idle(7000);
    rd('h0C, rv); chk("R8 all stopped", rv, 0);
    rd('h1C, rv);
    rd('h1C, rv); chk("R9 flags cleared by read", rv, 0);

    wr('h24C, 3); wr('h244, 1);
    rd('h24C, rv); chk("R7 direct period loads while stopped", rv, 3);
    wr('h04, 4); wr('h08, 4);
    idle(30);
    rd('h0C, rv); chk("R8 one period then stop", rv, 0);
    rd('h1C, rv); chk("R9 single period flag", rv, 4);

    wr('h200, 'h200); wr('h04, 1);
    idle(50);
    wr('h08, 1); wr('h04, 1);
    idle(40);
    rd('h0C, rv); chk("R2 restart after stop", rv, 0);

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule